// File: doc/BRIEF.md
# Timer Event and Status Flag Unit

This block holds the counting core, the sticky status flags and the forced-event logic of a 16-bit up-counting timer with two capture/compare channels. The counter runs from zero to a programmable reload value and wraps. A repetition counter decides which wraps become update events. Each channel either compares the running count with a threshold or latches the count when an input edge arrives. Every one of these occurrences raises a flag in a status register, and software clears a flag by writing zero to its bit.

Software can also force events through a write-only event register. Writing a bit there restarts the counter, raises a channel flag, or raises the commutation, trigger or break flag. Each event bit lives for exactly one cycle and then clears itself. A forced break also drops the main output enable. Capture inputs arrive as single-cycle edge pulses that are already synchronised.

Top module: `tmr_evt_flags`

## Requirements
- R1: While `cnt_en` is high, the counter steps by one on each clock. At the edge where it equals `arr_val`, it returns to 0 instead; this edge is an overflow.
- R2: An overflow with the repetition count at zero and `upd_dis` low is an update. It sets status bit 0 and reloads the repetition count from `rep_val`. An overflow with a nonzero repetition count decrements that count. After reset the repetition count is zero.
- R3: Event bit 0 returns the counter to 0. When `upd_dis` is low this counts as an update. Status bit 0 is set only if `upd_src` and `upd_dis` are both low.
- R4: A `trig_in` pulse returns the counter to 0 at that edge. It sets status bit 0 under the same condition as R3.
- R5: A channel in compare mode (`ch_capmode` bit 0) sets its status flag (bit 1 for channel 1, bit 2 for channel 2) at an enabled edge where the count equals its compare value.
- R6: When a compare value is above `arr_val`, that channel's flag is set at overflow instead.
- R7: A channel in capture mode samples the count into its capture output on an edge pulse of the selected polarity (`cap_pol` bit 0 means rising, 1 means falling), and sets its flag. A pulse of the other polarity changes neither the capture value nor the flag.
- R8: A `ccr_rd` strobe for a capture-mode channel clears that channel's flag.
- R9: A status write clears each bit written as 0 and leaves each bit written as 1 unchanged. A hardware set in the same cycle wins over the clear.
- R10: Event bits are: bit 0 update, 1 channel 1, 2 channel 2, 5 commutation, 6 trigger, 7 break. A bit is readable on `evg_rd` for one cycle after the write and then clears. Bits 3 and 4 always read 0 in both registers. The next edge sets the matching status bit (commutation, trigger and break flags use bits 5, 6, 7).
- R11: Event bit 7 clears `moe_q` and sets status bit 7. A `moe_set` pulse sets `moe_q`.
- R12: After reset, the count, status, event register, capture values and `moe_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable |
| arr_val | input | 16 | Reload (top) value |
| rep_val | input | 8 | Repetition reload value |
| upd_dis | input | 1 | Update disable |
| upd_src | input | 1 | Update source select (1: only overflow raises the flag) |
| trig_in | input | 1 | Trigger pulse that restarts the counter |
| ch_capmode | input | 2 | Per-channel mode: 1 capture, 0 compare |
| cap_pol | input | 2 | Per-channel capture polarity: 0 rising, 1 falling |
| cap_rise | input | 2 | Rising-edge pulses per channel |
| cap_fall | input | 2 | Falling-edge pulses per channel |
| cmp1_val | input | 16 | Channel 1 compare value |
| cmp2_val | input | 16 | Channel 2 compare value |
| ccr_rd | input | 2 | Capture register read strobes |
| evg_wr | input | 1 | Event register write strobe |
| evg_wdata | input | 8 | Event register write data |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status write data (0 clears a bit) |
| moe_set | input | 1 | Sets main output enable |
| cnt_q | output | 16 | Counter value |
| cap1_q | output | 16 | Channel 1 capture value |
| cap2_q | output | 16 | Channel 2 capture value |
| status_q | output | 8 | Status flags |
| evg_rd | output | 8 | Pending event bits |
| moe_q | output | 1 | Main output enable |

## Verification
Counting, trigger restarts, compare hits, capture edges, read strobes and status writes all take effect at the edge where the stimulus is present. Their results are sampled at the next falling edge. A software event needs one more edge: it shows on `evg_rd` after the write edge, and its effects on the counter, flags and `moe_q` appear one edge later. The bench therefore drives every stimulus at a falling edge and reads outputs only at falling edges. For event writes it samples `evg_rd` one falling edge after the write and the results one falling edge after that.

// File: rtl/tef_pkg.sv
package tef_pkg;
  localparam int NUM_CH = 2;
  localparam int EV_W   = 8;
  localparam int EV_UPD = 0;
  localparam int EV_CH1 = 1;
  localparam int EV_CH2 = 2;
  localparam int EV_COM = 5;
  localparam int EV_TRG = 6;
  localparam int EV_BRK = 7;
  localparam logic [EV_W-1:0] EV_MASK = 8'hE7;

  // capture edge selected by polarity: 0 rising, 1 falling
  function automatic logic f_cap_hit(input logic pol, input logic rise, input logic fall);
    return pol ? fall : rise;
  endfunction

  // compare hit: equality on an enabled step, or overflow when threshold is out of range
  function automatic logic f_cmp_hit(input logic [15:0] cnt, input logic [15:0] cmp,
                                     input logic [15:0] top, input logic step, input logic ovf);
    if (cmp > top) return ovf;
    return step && (cnt == cmp);
  endfunction

  // sticky flag update, set beats clear
  function automatic logic [EV_W-1:0] f_flag_next(input logic [EV_W-1:0] cur,
                                                  input logic [EV_W-1:0] set,
                                                  input logic [EV_W-1:0] clr);
    return ((cur & ~clr) | set) & EV_MASK;
  endfunction
endpackage

// File: rtl/tef_evgen.sv
module tef_evgen
  import tef_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] evg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evg_q <= '0;
    else if (wr) evg_q <= wdata & EV_MASK;
    else         evg_q <= '0;
  end
endmodule

// File: rtl/tef_counter.sv
module tef_counter #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] top,
  input  logic [RW-1:0] rep_val,
  input  logic          udis,
  input  logic          urs,
  input  logic          ug,
  input  logic          trig,
  output logic [CW-1:0] cnt,
  output logic          reinit,
  output logic          ovf_evt,
  output logic          upd_evt,
  output logic          uif_set
);
  logic [RW-1:0] rep;
  logic          rep_zero;

  always_comb begin
    reinit   = ug | trig;
    rep_zero = (rep == '0);
    ovf_evt  = en && !reinit && (cnt == top);
    if (reinit) begin
      upd_evt = !udis;
      uif_set = !udis && !urs;
    end else begin
      upd_evt = ovf_evt && rep_zero && !udis;
      uif_set = upd_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (reinit || ovf_evt) cnt <= '0;
    else if (en) cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep <= '0;
    else if (upd_evt) rep <= rep_val;
    else if (ovf_evt && !rep_zero) rep <= rep - RW'(1);
  end
endmodule

// File: rtl/tef_channel.sv
module tef_channel
  import tef_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] cmp,
  input  logic          step,
  input  logic          ovf,
  input  logic          capmode,
  input  logic          pol,
  input  logic          rise,
  input  logic          fall,
  input  logic          gen,
  input  logic          rd,
  output logic          cap_evt,
  output logic          set_evt,
  output logic          clr_evt,
  output logic [CW-1:0] cap_q
);
  logic cmp_evt;

  always_comb begin
    cap_evt = capmode && f_cap_hit(pol, rise, fall);
    cmp_evt = !capmode && f_cmp_hit(16'(cnt), 16'(cmp), 16'(top), step, ovf);
    set_evt = cap_evt || cmp_evt || gen;
    clr_evt = capmode && rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end
endmodule

// File: rtl/tef_flags.sv
module tef_flags
  import tef_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uif_set,
  input  logic [NUM_CH-1:0] ch_set,
  input  logic [NUM_CH-1:0] ch_clr,
  input  logic              com_set,
  input  logic              trg_set,
  input  logic              brk_set,
  input  logic              moe_set,
  input  logic              sts_wr,
  input  logic [EV_W-1:0]   sts_wdata,
  output logic [EV_W-1:0]   status_q,
  output logic              moe_q
);
  logic [EV_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = sts_wr ? ~sts_wdata : '0;
    set_v[EV_UPD] = uif_set;
    set_v[EV_COM] = com_set;
    set_v[EV_TRG] = trg_set;
    set_v[EV_BRK] = brk_set;
    for (int i = 0; i < NUM_CH; i++) begin
      set_v[EV_CH1 + i] = ch_set[i];
      clr_v[EV_CH1 + i] = clr_v[EV_CH1 + i] | ch_clr[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else status_q <= f_flag_next(status_q, set_v, clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) moe_q <= 1'b0;
    else if (brk_set) moe_q <= 1'b0;
    else if (moe_set) moe_q <= 1'b1;
  end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tef_pkg::*;
#(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [CW-1:0]     arr_val,
  input  logic [RW-1:0]     rep_val,
  input  logic              upd_dis,
  input  logic              upd_src,
  input  logic              trig_in,
  input  logic [NUM_CH-1:0] ch_capmode,
  input  logic [NUM_CH-1:0] cap_pol,
  input  logic [NUM_CH-1:0] cap_rise,
  input  logic [NUM_CH-1:0] cap_fall,
  input  logic [CW-1:0]     cmp1_val,
  input  logic [CW-1:0]     cmp2_val,
  input  logic [NUM_CH-1:0] ccr_rd,
  input  logic              evg_wr,
  input  logic [EV_W-1:0]   evg_wdata,
  input  logic              sts_wr,
  input  logic [EV_W-1:0]   sts_wdata,
  input  logic              moe_set,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     cap1_q,
  output logic [CW-1:0]     cap2_q,
  output logic [EV_W-1:0]   status_q,
  output logic [EV_W-1:0]   evg_rd,
  output logic              moe_q
);
  logic [EV_W-1:0]   evg_q;
  logic              reinit, ovf_evt, upd_evt, uif_set, step;
  logic [NUM_CH-1:0] cap_evt, ch_set, ch_clr;
  logic [CW-1:0]     cmp_arr [NUM_CH];
  logic [CW-1:0]     cap_arr [NUM_CH];

  assign cmp_arr[0] = cmp1_val;
  assign cmp_arr[1] = cmp2_val;
  assign cap1_q     = cap_arr[0];
  assign cap2_q     = cap_arr[1];
  assign evg_rd     = evg_q;
  assign step       = cnt_en && !reinit;

  tef_evgen u_evgen (
    .clk(clk), .rst_n(rst_n), .wr(evg_wr), .wdata(evg_wdata), .evg_q(evg_q)
  );

  tef_counter #(.CW(CW), .RW(RW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .top(arr_val), .rep_val(rep_val),
    .udis(upd_dis), .urs(upd_src), .ug(evg_q[EV_UPD]), .trig(trig_in),
    .cnt(cnt_q), .reinit(reinit), .ovf_evt(ovf_evt), .upd_evt(upd_evt),
    .uif_set(uif_set)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tef_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .top(arr_val), .cmp(cmp_arr[g]),
      .step(step), .ovf(ovf_evt), .capmode(ch_capmode[g]), .pol(cap_pol[g]),
      .rise(cap_rise[g]), .fall(cap_fall[g]), .gen(evg_q[EV_CH1 + g]),
      .rd(ccr_rd[g]), .cap_evt(cap_evt[g]), .set_evt(ch_set[g]),
      .clr_evt(ch_clr[g]), .cap_q(cap_arr[g])
    );
  end

  tef_flags u_flags (
    .clk(clk), .rst_n(rst_n), .uif_set(uif_set), .ch_set(ch_set), .ch_clr(ch_clr),
    .com_set(evg_q[EV_COM]), .trg_set(evg_q[EV_TRG]), .brk_set(evg_q[EV_BRK]),
    .moe_set(moe_set), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .status_q(status_q), .moe_q(moe_q)
  );
endmodule

// File: rtl/tef_checker.sv
module tef_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cnt_q,
  input logic [7:0]  status_q,
  input logic [7:0]  evg_q,
  input logic        evg_wr,
  input logic        moe_q,
  input logic        ovf_evt,
  input logic        uif_set,
  input logic        upd_dis,
  input logic        reinit,
  input logic [1:0]  cap_evt,
  input logic [1:0]  ch_set,
  input logic [1:0]  ccr_rd,
  input logic [1:0]  ch_capmode,
  input logic [15:0] cap1_q
);
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == 16'd0)); // R1
  AST_UIF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    uif_set |=> status_q[0]); // R2
  AST_UDIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dis && (ovf_evt || reinit)) |-> !uif_set); // R3
  AST_EVG_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evg_q) && !evg_wr) |=> (evg_q == 8'd0)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evg_q[4:3] == 2'b00) && (status_q[4:3] == 2'b00)); // R10
  AST_BRK_MOE: assert property (@(posedge clk) disable iff (!rst_n)
    evg_q[7] |=> (!moe_q && status_q[7])); // R11
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt[0] |=> $stable(cap1_q)); // R7
  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_rd[0] && ch_capmode[0] && !ch_set[0]) |=> !status_q[1]); // R8
endmodule

bind tmr_evt_flags tef_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .status_q(status_q), .evg_q(evg_q),
  .evg_wr(evg_wr), .moe_q(moe_q), .ovf_evt(ovf_evt), .uif_set(uif_set),
  .upd_dis(upd_dis), .reinit(reinit), .cap_evt(cap_evt), .ch_set(ch_set),
  .ccr_rd(ccr_rd), .ch_capmode(ch_capmode), .cap1_q(cap1_q)
);

// File: tb/tmr_evt_flags_tb.sv
`timescale 1ns/100ps
module tmr_evt_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n, cnt_en, upd_dis, upd_src, trig_in, evg_wr, sts_wr, moe_set;
  logic [15:0] arr_val, cmp1_val, cmp2_val;
  logic [7:0]  rep_val, evg_wdata, sts_wdata;
  logic [1:0]  ch_capmode, cap_pol, cap_rise, cap_fall, ccr_rd;
  logic [15:0] cnt_q, cap1_q, cap2_q;
  logic [7:0]  status_q, evg_rd;
  logic        moe_q;
  int checks = 0, errors = 0;
  logic [7:0] mid;

  always #2.5 clk = ~clk;

  tmr_evt_flags u_dut (.*);

  typedef struct packed {
    logic [15:0] arr; logic [15:0] cmp; logic [7:0] n;
    logic [15:0] ecnt; logic euif; logic ecc;
  } vec_t;
  // counter runs n enabled edges from zero; compare-mode channel 1
  localparam vec_t VECS [8] = '{
    '{16'd9, 16'd3,  8'd3,  16'd3, 1'b0, 1'b0},
    '{16'd9, 16'd3,  8'd4,  16'd4, 1'b0, 1'b1},
    '{16'd9, 16'd3,  8'd10, 16'd0, 1'b1, 1'b1},
    '{16'd9, 16'd12, 8'd9,  16'd9, 1'b0, 1'b0},
    '{16'd9, 16'd12, 8'd10, 16'd0, 1'b1, 1'b1},
    '{16'd4, 16'd4,  8'd4,  16'd4, 1'b0, 1'b0},
    '{16'd4, 16'd4,  8'd7,  16'd2, 1'b1, 1'b1},
    '{16'd0, 16'd0,  8'd3,  16'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] top);
    rst_n = 1'b0; cnt_en = 0; upd_dis = 0; upd_src = 0; trig_in = 0;
    evg_wr = 0; sts_wr = 0; moe_set = 0; arr_val = top; cmp1_val = 16'hFFFF;
    cmp2_val = 16'hFFFF; rep_val = 0; evg_wdata = 0; sts_wdata = 0;
    ch_capmode = 0; cap_pol = 0; cap_rise = 0; cap_fall = 0; ccr_rd = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    @(negedge clk) cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) cnt_en = 1'b0;
  endtask

  task automatic evg(input logic [7:0] d, output logic [7:0] pend);
    @(negedge clk) begin evg_wr = 1'b1; evg_wdata = d; end
    @(negedge clk) begin evg_wr = 1'b0; pend = evg_rd; end
    @(negedge clk);
  endtask

  task automatic sts(input logic [7:0] d);
    @(negedge clk) begin sts_wr = 1'b1; sts_wdata = d; end
    @(negedge clk) sts_wr = 1'b0;
  endtask

  task automatic pulse(input int kind, input logic [1:0] v);
    @(negedge clk) case (kind)
      0: cap_rise = v; 1: cap_fall = v; 2: ccr_rd = v; 3: trig_in = v[0]; default: moe_set = v[0];
    endcase
    @(negedge clk) begin cap_rise = 0; cap_fall = 0; ccr_rd = 0; trig_in = 0; moe_set = 0; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12 reset state
    do_reset(16'd9);
    chk("R12 cnt", cnt_q, 0); chk("R12 status", status_q, 0);
    chk("R12 evg", evg_rd, 0); chk("R12 moe", moe_q, 0);
    chk("R12 cap", {cap1_q, cap2_q}, 0);

    // R1 R5 R6 vector table
    foreach (VECS[i]) begin
      do_reset(VECS[i].arr);
      cmp1_val = VECS[i].cmp;
      run(int'(VECS[i].n));
      chk("R1 count", cnt_q, VECS[i].ecnt);
      chk("R2 update flag", status_q[0], VECS[i].euif);
      chk(VECS[i].cmp > VECS[i].arr ? "R6 overflow compare" : "R5 compare", status_q[1], VECS[i].ecc);
    end

    // R2 repetition
    do_reset(16'd1); rep_val = 8'd2;
    run(2); chk("R2 first overflow", status_q[0], 1);
    sts(8'h00); run(5); chk("R2 repetition holds", status_q[0], 0);
    run(1); chk("R2 repetition expires", status_q[0], 1);
    do_reset(16'd1); upd_dis = 1'b1;
    run(6); chk("R2 udis blocks", status_q[0], 0); chk("R1 wraps under udis", cnt_q, 0);

    // R3 software update
    do_reset(16'd100);
    run(5); chk("R1 pre-UG count", cnt_q, 5);
    upd_src = 1'b1; evg(8'h01, mid);
    chk("R10 pending UG", mid, 8'h01); chk("R3 UG restarts", cnt_q, 0);
    chk("R3 URS blocks flag", status_q[0], 0); chk("R10 self-clear", evg_rd, 0);
    upd_src = 1'b0; run(3); evg(8'h01, mid);
    chk("R3 UG restart", cnt_q, 0); chk("R3 UG flag", status_q[0], 1);
    sts(8'h00); upd_dis = 1'b1; evg(8'h01, mid);
    chk("R3 UDIS blocks flag", status_q[0], 0); upd_dis = 1'b0;

    // R4 trigger restart
    run(4); pulse(3, 2'b01);
    chk("R4 trigger restart", cnt_q, 0); chk("R4 trigger flag", status_q[0], 1);
    sts(8'h00); upd_src = 1'b1; run(2); pulse(3, 2'b01);
    chk("R4 trigger restart urs", cnt_q, 0); chk("R4 urs blocks flag", status_q[0], 0);

    // R10 R11 R9 events and status writes
    do_reset(16'd100);
    pulse(4, 2'b01); chk("R11 moe set", moe_q, 1);
    evg(8'hFF, mid);
    chk("R10 reserved masked", mid, 8'hE7); chk("R10 all flags", status_q, 8'hE7);
    chk("R11 break clears moe", moe_q, 0); chk("R10 cleared", evg_rd, 0);
    sts(8'hFE); chk("R9 write zero clears", status_q, 8'hE6);
    sts(8'hFF); chk("R9 write one no effect", status_q, 8'hE6);

    // R7 R8 capture
    do_reset(16'd100); ch_capmode = 2'b11; cap_pol = 2'b10;
    run(3); pulse(0, 2'b01);
    chk("R7 capture value", cap1_q, 3); chk("R7 capture flag", status_q, 8'h02);
    run(2); pulse(1, 2'b01);
    chk("R7 wrong polarity value", cap1_q, 3); chk("R7 wrong polarity flag", status_q, 8'h02);
    pulse(1, 2'b10);
    chk("R7 falling capture", cap2_q, 5); chk("R7 ch2 flag", status_q, 8'h06);
    run(1); pulse(0, 2'b10); chk("R7 ch2 rising ignored", cap2_q, 5);
    pulse(2, 2'b01); chk("R8 read clears", status_q, 8'h04);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule